// File: doc/BRIEF.md
# Serial Adapter Host Register Interface

This block sits between a host bus and the bit-level transmitter and receiver of an asynchronous serial adapter. A select line and a read/write strobe pick one of two addresses. At address 0 a write loads the control register and a read returns the status byte. At address 1 a write loads the transmit holding register and a read returns the received character. Reads are combinational, so data comes back in the cycle it is requested. Their side effects, such as clearing flags, take hold at the clock edge that ends that cycle.

The control register sets the character format and the clock divide ratio for the serial engines. It also sets the request-to-send output, the break output and the interrupt enables. The block keeps the receive-full, overrun, parity, framing and carrier flags, and the transmit-empty flag. It merges these with the clear-to-send line into the status byte and drives an active-low interrupt output that mirrors status bit 7.

After reset the adapter stays in master reset until the host writes divide code 11. Only after that write may another divide code be selected.

Top module: `sadp_regif`

## Requirements
- R1: After rst_ni the block holds master reset (in_reset_o=1), and a control write whose bits 1:0 are not 11 is ignored until a control write with bits 1:0 = 11 has occurred.
- R2: A control write with bits 1:0 = 11 clears receive-full, overrun and the carrier flag from the next cycle. Status bit 3 keeps following cts_line_i. Received characters are ignored while master reset holds.
- R3: Control bits 6:5 select transmit behaviour. 00 gives rts_n_o=0 with the transmit interrupt off. 01 gives rts_n_o=0 with the transmit interrupt on. 10 gives rts_n_o=1 with the transmit interrupt off. 11 gives rts_n_o=0 and tx_break_o=1 with the transmit interrupt off.
- R4: The status byte, from bit 7 down to bit 0, is: interrupt, parity error, overrun, framing error, clear to send, carrier detect, transmit empty, receive full. After leaving reset with no activity it reads 0x02.
- R5: rx_load_i with the receive register empty stores rx_data_i and sets receive-full. A read at address 1 returns that character and clears receive-full and overrun.
- R6: rx_load_i while receive-full is set and no read occurs in the same cycle sets overrun and keeps the earlier character.
- R7: Each stored character refreshes the parity-error and framing-error flags. The parity error is forced to 0 when control bits 4:2 select no parity (100 or 101).
- R8: A write at address 1 latches tx_data_o, raises tx_valid_o and clears transmit-empty. tx_take_i sets transmit-empty again.
- R9: While cts_line_i is 1, status bit 1 reads 0 and the transmit interrupt cannot assert.
- R10: A rising edge on dcd_line_i sets the carrier flag. Only a status read followed later by a read at address 1 clears it; a read at address 1 alone leaves it set.
- R11: With control bit 7 set, receive-full, overrun or the carrier flag assert the interrupt. With transmit code 01, visible transmit-empty asserts it. irq_n_o is the inverse of status bit 7.
- R12: rdata_o is 0 unless cs_i and rw_i are both 1, and a bus cycle with cs_i low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select |
| rs_i | input | 1 | Register select: 0 control/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid in the read cycle |
| rx_load_i | input | 1 | Receiver has a new character |
| rx_data_i | input | DW | Received character |
| rx_par_err_i | input | 1 | Parity check failed for that character |
| rx_frm_err_i | input | 1 | Stop bit missing for that character |
| tx_take_i | input | 1 | Transmitter consumed the holding register |
| tx_valid_o | output | 1 | Holding register contains a character |
| tx_data_o | output | DW | Holding register contents |
| tx_break_o | output | 1 | Transmitter must send continuous break |
| cts_line_i | input | 1 | Clear-to-send line, 1 = not ready |
| dcd_line_i | input | 1 | Carrier-detect line, synchronised |
| rts_n_o | output | 1 | Request to send, active low |
| irq_n_o | output | 1 | Interrupt request, active low |
| word_sel_o | output | 3 | Character format code (control bits 4:2) |
| clk_div_o | output | 2 | Divide code (control bits 1:0) |
| in_reset_o | output | 1 | Master reset in force |

## Verification
The bench first attempts a control write before any master reset. A design that skipped the power-up lock would raise rts_n_o there. The bench then checks that a second character arriving while the first is unread sets overrun and leaves the first character readable; a design that overwrote the buffer would return the wrong byte. The carrier flag is cleared once with a receive read alone and once with a status read first. A design that ignored the ordering would clear too early or never. Clear-to-send is raised with the transmit interrupt on, which catches a design that let transmit-empty through to the status byte or to irq_n_o. Parity masking is checked under a no-parity format, and master reset is checked against the clear-to-send bit it must leave alone.

// File: rtl/sadp_pkg.sv
package sadp_pkg;
  localparam int ST_W    = 8;
  localparam int ST_IRQ  = 7;
  localparam int ST_PE   = 6;
  localparam int ST_OVR  = 5;
  localparam int ST_FE   = 4;
  localparam int ST_CTS  = 3;
  localparam int ST_DCD  = 2;
  localparam int ST_TDRE = 1;
  localparam int ST_RDRF = 0;

  localparam logic [1:0] DIV_MRST = 2'b11;

  typedef enum logic [1:0] {
    TXC_ON_QUIET = 2'b00,
    TXC_ON_INT   = 2'b01,
    TXC_OFF      = 2'b10,
    TXC_BREAK    = 2'b11
  } txc_e;
endpackage

// File: rtl/sadp_ctrl.sv
module sadp_ctrl
  import sadp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rx_ie_o,
  output txc_e          txc_o,
  output logic [2:0]    word_o,
  output logic [1:0]    div_o,
  output logic          in_reset_o,
  output logic          mrst_now_o
);
  logic [7:0] ctrl_q;
  logic       armed_q;

  assign mrst_now_o = wr_i && (wdata_i[1:0] == DIV_MRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else if (mrst_now_o) begin
      ctrl_q  <= wdata_i[7:0];
      armed_q <= 1'b1;
    end else if (wr_i && armed_q) begin
      ctrl_q  <= wdata_i[7:0];
    end
  end

  assign in_reset_o = !armed_q || (ctrl_q[1:0] == DIV_MRST);
  assign rx_ie_o    = ctrl_q[7];
  assign txc_o      = txc_e'(ctrl_q[6:5]);
  assign word_o     = ctrl_q[4:2];
  assign div_o      = ctrl_q[1:0];
endmodule

// File: rtl/sadp_rx_flags.sv
module sadp_rx_flags #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          pe_i,
  input  logic          fe_i,
  input  logic          par_en_i,
  input  logic          rd_i,
  output logic          full_o,
  output logic          ovr_o,
  output logic          pe_o,
  output logic          fe_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
    end else if (load_i && (!full_o || rd_i)) begin
      data_o <= data_i;
      full_o <= 1'b1;
      pe_o   <= pe_i && par_en_i;
      fe_o   <= fe_i;
      if (rd_i) ovr_o <= 1'b0;
    end else if (load_i) begin
      ovr_o  <= 1'b1;  // new char dropped, old kept
    end else if (rd_i) begin
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sadp_tx_hold.sv
module sadp_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic          empty_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      data_o  <= '0;
    end else if (clr_i) begin
      empty_o <= 1'b1;
    end else if (wr_i) begin
      empty_o <= 1'b0;
      data_o  <= wdata_i;
    end else if (take_i) begin
      empty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sadp_dcd.sv
module sadp_dcd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic line_i,
  input  logic stat_rd_i,
  input  logic rx_rd_i,
  output logic flag_o
);
  logic prev_q;
  logic seen_q;
  logic rise;

  assign rise = line_i && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      seen_q <= 1'b0;
    end else if (rise) begin
      flag_o <= 1'b1;
      seen_q <= 1'b0;
    end else if (rx_rd_i && seen_q) begin
      flag_o <= 1'b0;
      seen_q <= 1'b0;
    end else if (stat_rd_i && flag_o) begin
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sadp_regif.sv
module sadp_regif
  import sadp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_par_err_i,
  input  logic          rx_frm_err_i,
  input  logic          tx_take_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_break_o,
  input  logic          cts_line_i,
  input  logic          dcd_line_i,
  output logic          rts_n_o,
  output logic          irq_n_o,
  output logic [2:0]    word_sel_o,
  output logic [1:0]    clk_div_o,
  output logic          in_reset_o
);
  logic            rd_stat, rd_rx, wr_ctrl, wr_tx;
  logic            rx_ie, mrst_now, clr;
  txc_e            txc;
  logic            rx_full, rx_ovr, rx_pe, rx_fe;
  logic [DW-1:0]   rx_data;
  logic            tx_empty, tdre_vis, dcd_flag, irq;
  logic [ST_W-1:0] stat_w;

  assign rd_stat = cs_i &&  rw_i && !rs_i;
  assign rd_rx   = cs_i &&  rw_i &&  rs_i;
  assign wr_ctrl = cs_i && !rw_i && !rs_i;
  assign wr_tx   = cs_i && !rw_i &&  rs_i;

  sadp_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_ctrl), .wdata_i,
    .rx_ie_o(rx_ie), .txc_o(txc), .word_o(word_sel_o), .div_o(clk_div_o),
    .in_reset_o, .mrst_now_o(mrst_now)
  );

  assign clr = in_reset_o || mrst_now;

  sadp_rx_flags #(.DW(DW)) u_rx (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(rx_load_i), .data_i(rx_data_i),
    .pe_i(rx_par_err_i), .fe_i(rx_frm_err_i),
    .par_en_i(word_sel_o[2:1] != 2'b10), .rd_i(rd_rx),
    .full_o(rx_full), .ovr_o(rx_ovr), .pe_o(rx_pe), .fe_o(rx_fe), .data_o(rx_data)
  );

  sadp_tx_hold #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_tx), .wdata_i, .take_i(tx_take_i),
    .empty_o(tx_empty), .data_o(tx_data_o)
  );

  sadp_dcd u_dcd (
    .clk_i, .rst_ni, .clr_i(clr), .line_i(dcd_line_i),
    .stat_rd_i(rd_stat), .rx_rd_i(rd_rx), .flag_o(dcd_flag)
  );

  assign tdre_vis = tx_empty && !cts_line_i;
  assign irq = (rx_ie && (rx_full || rx_ovr || dcd_flag)) ||
               ((txc == TXC_ON_INT) && tdre_vis);

  always_comb begin
    stat_w          = '0;
    stat_w[ST_IRQ]  = irq;
    stat_w[ST_PE]   = rx_pe;
    stat_w[ST_OVR]  = rx_ovr;
    stat_w[ST_FE]   = rx_fe;
    stat_w[ST_CTS]  = cts_line_i;
    stat_w[ST_DCD]  = dcd_flag;
    stat_w[ST_TDRE] = tdre_vis;
    stat_w[ST_RDRF] = rx_full;
  end

  always_comb begin
    if (rd_stat)    rdata_o = DW'(stat_w);
    else if (rd_rx) rdata_o = rx_data;
    else            rdata_o = '0;
  end

  assign irq_n_o    = !irq;
  assign rts_n_o    = (txc == TXC_OFF);
  assign tx_break_o = (txc == TXC_BREAK);
  assign tx_valid_o = !tx_empty;
endmodule

// File: rtl/sadp_regif_chk.sv
module sadp_regif_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          rs_i,
  input logic          rw_i,
  input logic [DW-1:0] wdata_i,
  input logic          rx_load_i,
  input logic          cts_line_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_n_o,
  input logic          rts_n_o,
  input logic          tx_break_o,
  input logic          in_reset_o,
  input logic [7:0]    stat_i
);
  logic mrst_wr, rx_rd;
  assign mrst_wr = cs_i && !rw_i && !rs_i && (wdata_i[1:0] == 2'b11);
  assign rx_rd   = cs_i && rw_i && rs_i;

  AST_MRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_wr |=> (!stat_i[0] && !stat_i[5] && !stat_i[2])); // R2
  AST_BREAK_RTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_break_o |-> !rts_n_o); // R3
  AST_RX_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && !rx_load_i) |=> (!stat_i[0] && !stat_i[5])); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[0] && rx_load_i && !rx_rd && !mrst_wr && !in_reset_o) |=> stat_i[5]); // R6
  AST_CTS_HIDES_TDRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_line_i |-> (!stat_i[1] && stat_i[3])); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> (stat_i[0] || stat_i[1] || stat_i[2] || stat_i[5])); // R11
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rw_i) |-> (rdata_o == '0)); // R12
endmodule

bind sadp_regif sadp_regif_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rs_i(rs_i), .rw_i(rw_i),
  .wdata_i(wdata_i), .rx_load_i(rx_load_i), .cts_line_i(cts_line_i),
  .rdata_o(rdata_o), .irq_n_o(irq_n_o), .rts_n_o(rts_n_o),
  .tx_break_o(tx_break_o), .in_reset_o(in_reset_o), .stat_i(stat_w)
);

// File: tb/sadp_regif_tb.sv
module sadp_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0, rs_i = 1'b0, rw_i = 1'b1;
  logic [DW-1:0] wdata_i = '0, rx_data_i = '0;
  logic rx_load_i = 1'b0, rx_par_err_i = 1'b0, rx_frm_err_i = 1'b0;
  logic tx_take_i = 1'b0, cts_line_i = 1'b0, dcd_line_i = 1'b0;
  logic [DW-1:0] rdata_o, tx_data_o;
  logic tx_valid_o, tx_break_o, rts_n_o, irq_n_o, in_reset_o;
  logic [2:0] word_sel_o;
  logic [1:0] clk_div_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadp_regif #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni, .cs_i, .rs_i, .rw_i, .wdata_i, .rdata_o,
    .rx_load_i, .rx_data_i, .rx_par_err_i, .rx_frm_err_i, .tx_take_i,
    .tx_valid_o, .tx_data_o, .tx_break_o, .cts_line_i, .dcd_line_i,
    .rts_n_o, .irq_n_o, .word_sel_o, .clk_div_o, .in_reset_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic rs, input logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; rs_i = rs; rw_i = 1'b0; wdata_i = d;
    @(negedge clk);
    cs_i = 1'b0; rw_i = 1'b1; #1;
  endtask

  task automatic bus_rd(input logic rs, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; rs_i = rs; rw_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 1'b0; #1;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    rx_load_i = 1'b1; rx_data_i = d; rx_par_err_i = pe; rx_frm_err_i = fe;
    @(negedge clk);
    rx_load_i = 1'b0; #1;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    chk("R1 in_reset", 8'(in_reset_o), 8'h1);
    chk("R11 irq_n idle", 8'(irq_n_o), 8'h1);
    bus_rd(1'b0, v);
    chk("R4 status after reset", v, 8'h02);
  endtask

  task automatic t_power_lock();
    logic [7:0] v;
    bus_wr(1'b0, 8'h40);
    chk("R1 write before arm ignored rts", 8'(rts_n_o), 8'h0);
    chk("R1 still in reset", 8'(in_reset_o), 8'h1);
    rx_push(8'h77, 1'b0, 1'b0);
    bus_rd(1'b0, v);
    chk("R2 rx ignored in reset", v, 8'h02);
    bus_wr(1'b0, 8'h03);
    chk("R1 mrst keeps reset", 8'(in_reset_o), 8'h1);
    bus_wr(1'b0, 8'h55);
    chk("R1 out of reset", 8'(in_reset_o), 8'h0);
    chk("R3 code10 rts high", 8'(rts_n_o), 8'h1);
    chk("R1 div", 8'(clk_div_o), 8'h1);
    chk("R1 word", 8'(word_sel_o), 8'h5);
  endtask

  task automatic t_tx_codes();
    logic [7:0] v;
    bus_wr(1'b0, 8'h15);
    chk("R3 code00 rts", 8'(rts_n_o), 8'h0);
    chk("R3 code00 no irq", 8'(irq_n_o), 8'h1);
    bus_wr(1'b0, 8'h35);
    chk("R3 code01 irq", 8'(irq_n_o), 8'h0);
    bus_rd(1'b0, v);
    chk("R11 status irq bit", v, 8'h82);
    bus_wr(1'b0, 8'h75);
    chk("R3 code11 break", 8'(tx_break_o), 8'h1);
    chk("R3 code11 rts", 8'(rts_n_o), 8'h0);
    chk("R3 code11 no irq", 8'(irq_n_o), 8'h1);
    bus_wr(1'b0, 8'h95);
    chk("R3 break off", 8'(tx_break_o), 8'h0);
  endtask

  task automatic t_rx_basic();
    logic [7:0] v;
    rx_push(8'hA5, 1'b0, 1'b0);
    chk("R11 rx irq", 8'(irq_n_o), 8'h0);
    bus_rd(1'b0, v);
    chk("R5 status full", v, 8'h83);
    bus_rd(1'b1, v);
    chk("R5 rx data", v, 8'hA5);
    bus_rd(1'b0, v);
    chk("R5 status cleared", v, 8'h02);
    chk("R11 irq released", 8'(irq_n_o), 8'h1);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    rx_push(8'h11, 1'b0, 1'b0);
    rx_push(8'h22, 1'b0, 1'b0);
    bus_rd(1'b0, v);
    chk("R6 overrun status", v, 8'hA3);
    bus_rd(1'b1, v);
    chk("R6 first char kept", v, 8'h11);
    bus_rd(1'b0, v);
    chk("R5 overrun cleared", v, 8'h02);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    rx_push(8'h01, 1'b1, 1'b1);
    bus_rd(1'b0, v);
    chk("R7 no parity mask", v, 8'h93);
    bus_rd(1'b1, v);
    bus_wr(1'b0, 8'h99);
    rx_push(8'h02, 1'b1, 1'b0);
    bus_rd(1'b0, v);
    chk("R7 parity err", v, 8'hC3);
    bus_rd(1'b1, v);
    rx_push(8'h03, 1'b0, 1'b0);
    bus_rd(1'b0, v);
    chk("R7 flags refreshed", v, 8'h83);
    bus_rd(1'b1, v);
    bus_wr(1'b0, 8'h95);
  endtask

  task automatic t_tx_hold();
    logic [7:0] v;
    bus_wr(1'b1, 8'h3C);
    chk("R8 tx valid", 8'(tx_valid_o), 8'h1);
    chk("R8 tx data", tx_data_o, 8'h3C);
    bus_rd(1'b0, v);
    chk("R8 tdre low", v, 8'h00);
    @(negedge clk); tx_take_i = 1'b1;
    @(negedge clk); tx_take_i = 1'b0; #1;
    chk("R8 tx taken", 8'(tx_valid_o), 8'h0);
    bus_rd(1'b0, v);
    chk("R8 tdre back", v, 8'h02);
  endtask

  task automatic t_cts();
    logic [7:0] v;
    bus_wr(1'b0, 8'hB5);
    cts_line_i = 1'b1; #1;
    chk("R9 no tx irq under cts", 8'(irq_n_o), 8'h1);
    bus_rd(1'b0, v);
    chk("R9 status cts", v, 8'h08);
    cts_line_i = 1'b0; #1;
    chk("R11 tx irq", 8'(irq_n_o), 8'h0);
    bus_wr(1'b0, 8'h95);
  endtask

  task automatic t_dcd();
    logic [7:0] v;
    @(negedge clk); dcd_line_i = 1'b1;
    @(negedge clk); #1;
    chk("R10 dcd irq", 8'(irq_n_o), 8'h0);
    bus_rd(1'b1, v);
    chk("R10 rx read alone keeps", 8'(irq_n_o), 8'h0);
    bus_rd(1'b0, v);
    chk("R10 status dcd", v, 8'h86);
    bus_rd(1'b1, v);
    bus_rd(1'b0, v);
    chk("R10 dcd cleared", v, 8'h02);
    @(negedge clk); dcd_line_i = 1'b0;
  endtask

  task automatic t_mrst();
    logic [7:0] v;
    @(negedge clk); dcd_line_i = 1'b1;
    rx_push(8'h44, 1'b0, 1'b0);
    rx_push(8'h45, 1'b0, 1'b0);
    cts_line_i = 1'b1;
    bus_rd(1'b0, v);
    chk("R2 before mrst", v, 8'hAD);
    bus_wr(1'b0, 8'h03);
    chk("R2 in reset", 8'(in_reset_o), 8'h1);
    bus_rd(1'b0, v);
    chk("R2 flags cleared cts kept", v, 8'h08);
    bus_wr(1'b0, 8'h95);
    cts_line_i = 1'b0;
    bus_rd(1'b0, v);
    chk("R2 after rearm", v, 8'h02);
    dcd_line_i = 1'b0;
  endtask

  task automatic t_idle_bus();
    logic [7:0] v;
    rx_push(8'h5A, 1'b0, 1'b0);
    @(negedge clk); rs_i = 1'b1; rw_i = 1'b1; cs_i = 1'b0; #1;
    chk("R12 rdata zero unselected", rdata_o, 8'h00);
    @(negedge clk); #1;
    bus_rd(1'b0, v);
    chk("R12 no side effect", v, 8'h83);
    bus_rd(1'b1, v);
    chk("R12 data intact", v, 8'h5A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    t_reset_state();
    t_power_lock();
    t_tx_codes();
    t_rx_basic();
    t_overrun();
    t_parity();
    t_tx_hold();
    t_cts();
    t_dcd();
    t_mrst();
    t_idle_bus();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule